// File: doc/BRIEF.md
# DMA Trigger Source Selector

This block routes hardware and software events to the request inputs of a four-channel high-speed DMA engine. Each channel holds a 4-bit source code. The code picks one event from a fixed set: a software strobe, the falling or rising edge of the channel's external request pin, ten channel-specific peripheral lines, or a conversion-complete event that all channels share. When the chosen event occurs on an enabled channel, the block emits a one-cycle DMA request pulse.

Routing takes no account of any interrupt flag, enable, mask or priority. For a hardware cause, the block also emits the matching CPU interrupt pulse a fixed two clocks after the DMA request. The DMA engine and the CPU can then act on the same event at the same time.

The source code of a channel is loaded through a per-channel write strobe. Register bus decoding, the transfer engine and interrupt arbitration sit outside this block.

Top module: `dma_trig_router`

## Requirements
- R1: After reset every channel's source code is 0000 (software). A `sw_trig` strobe sampled high on an enabled channel then produces a `dma_req` pulse on the next clock edge.
- R2: Code 0001 requests on a falling edge of `ext_req[c]`. The pulse appears on the third rising edge that samples the new pin level, after two synchronizer stages. A rising edge is ignored under this code.
- R3: Code 0010 requests on a rising edge of `ext_req[c]` with the same latency as R2. A falling edge is ignored under this code.
- R4: Codes 0101 and 1111 never produce a request on any channel. Code 1000 is also reserved on channel 2, and codes 1000 and 1011 are reserved on channel 3.
- R5: While `ch_en[c]` is low, channel c produces no request for any selected event.
- R6: Codes 0011, 0100, 0110, 0111, 1000, 1001, 1010, 1011, 1101 and 1110 select peripheral line index 0 to 9 in that order. The line is bit c*10+index of `per_src`. A rising level gives exactly one one-cycle request on the next edge, even while the line stays high.
- R7: Code 1100 selects the shared `conv_done` line. One rising edge of it requests on every enabled channel with that code in the same cycle.
- R8: `cpu_irq[c]` pulses exactly two clocks after a `dma_req[c]` pulse caused by a hardware event. A software-caused request raises no `cpu_irq`.
- R9: A `sw_trig` strobe has no effect while a channel's code is not 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_we | input | NUM_CH | Per-channel load strobe for the source code |
| sel_wdata | input | 4 | Source code loaded by `sel_we` |
| ch_en | input | NUM_CH | Per-channel DMA enable |
| sw_trig | input | NUM_CH | Per-channel software strobe |
| ext_req | input | NUM_CH | Asynchronous external request pins, idle high |
| per_src | input | NUM_CH*10 | Per-channel peripheral level lines |
| conv_done | input | 1 | Shared conversion-complete level |
| dma_req | output | NUM_CH | One-cycle DMA request pulses |
| cpu_irq | output | NUM_CH | CPU interrupt pulses, two clocks after the hardware-caused request |

## Verification
The bench builds the block with its defaults: four channels, two synchronizer stages and the default reserved-code map. This puts the per-channel reserved codes of channels 2 and 3 within reach, and the three-edge pin latency can be counted directly. With four channels, the shared conversion-complete code can be shown to fire all channels in one cycle. A held peripheral line is kept high for a full observation window, so a repeat request would be seen.

// File: rtl/dma_trig_pkg.sv
// Shared constants and the code-to-line map for the DMA trigger selector.
// Assumes a 4-bit source code; the code points are fixed by behaviour.
package dma_trig_pkg;
    localparam int CODE_W    = 4;
    localparam int NUM_CODES = 1 << CODE_W;
    localparam int NUM_PER   = 10;
    localparam int IRQ_LAG   = 2;

    localparam logic [CODE_W-1:0] CODE_SW   = 4'd0;
    localparam logic [CODE_W-1:0] CODE_FALL = 4'd1;
    localparam logic [CODE_W-1:0] CODE_RISE = 4'd2;
    localparam logic [CODE_W-1:0] CODE_CONV = 4'd12;

    // Code point that selects peripheral line idx of a channel.
    function automatic logic [CODE_W-1:0] per_code(input int idx);
        case (idx)
            0:       return 4'd3;
            1:       return 4'd4;
            2:       return 4'd6;
            3:       return 4'd7;
            4:       return 4'd8;
            5:       return 4'd9;
            6:       return 4'd10;
            7:       return 4'd11;
            8:       return 4'd13;
            9:       return 4'd14;
            default: return 4'd15;
        endcase
    endfunction
endpackage

// File: rtl/trig_ext_edge.sv
// Synchronizes one asynchronous request pin and flags its edges.
// Assumes the pin idles high; the chain resets to ones so release gives no edge.
module trig_ext_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the pin through the synchronizer and keep the previous settled level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;
    assign fall = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/trig_chan.sv
// One channel: holds the source code and picks the selected event.
// Registers a one-cycle request and marks whether it had a hardware cause.
// Assumes the edge inputs are already one-cycle pulses; level lines are edged here.
module trig_chan
    import dma_trig_pkg::*;
#(
    parameter logic [NUM_CODES-1:0] RSVD = 16'h8020
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_we,
    input  logic [CODE_W-1:0]  sel_wdata,
    input  logic               en,
    input  logic               sw,
    input  logic               ext_rise,
    input  logic               ext_fall,
    input  logic [NUM_PER-1:0] per_lvl,
    input  logic               conv_pulse,
    output logic [CODE_W-1:0]  sel_q,
    output logic               req,
    output logic               hw
);
    logic [NUM_PER-1:0]   per_last;
    logic [NUM_PER-1:0]   per_pulse;
    logic [NUM_CODES-1:0] ev_by_code;
    logic                 hit;

    // Source code register, loaded by its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= CODE_SW;
        else if (sel_we) sel_q <= sel_wdata;
    end

    // Remember peripheral levels so that each rise counts only once.
    always_ff @(posedge clk) begin
        if (!rst_n) per_last <= '0;
        else per_last <= per_lvl;
    end

    assign per_pulse = per_lvl & ~per_last;

    // Place every event at its code point.
    always_comb begin
        ev_by_code            = '0;
        ev_by_code[CODE_SW]   = sw;
        ev_by_code[CODE_FALL] = ext_fall;
        ev_by_code[CODE_RISE] = ext_rise;
        ev_by_code[CODE_CONV] = conv_pulse;
        for (int i = 0; i < NUM_PER; i++) begin
            ev_by_code[per_code(i)] = per_pulse[i];
        end
    end

    assign hit = en & ev_by_code[sel_q] & ~RSVD[sel_q];

    // Register the request and its cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= 1'b0;
            hw  <= 1'b0;
        end else begin
            req <= hit;
            hw  <= hit & (sel_q != CODE_SW);
        end
    end
endmodule

// File: rtl/trig_irq_delay.sv
// Delays a hardware-cause request pulse by DEPTH clocks for the CPU interrupt.
// Assumes DEPTH is at least 1.
module trig_irq_delay #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [DEPTH-1:0] sr_q;

    generate
        if (DEPTH == 1) begin : g_one
            // Single stage delay.
            always_ff @(posedge clk) begin
                if (!rst_n) sr_q <= '0;
                else sr_q <= d;
            end
        end else begin : g_many
            // Shift chain delay.
            always_ff @(posedge clk) begin
                if (!rst_n) sr_q <= '0;
                else sr_q <= {sr_q[DEPTH-2:0], d};
            end
        end
    endgenerate

    assign q = sr_q[DEPTH-1];
endmodule

// File: rtl/dma_trig_router.sv
// Top of the DMA trigger selector: per channel, pin edge detection, source
// selection and the interrupt delay. It also edges the shared conversion line.
// Assumes all level inputs are synchronous except ext_req.
module dma_trig_router
    import dma_trig_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int SYNC_STAGES = 2,
    parameter logic [NUM_CH*NUM_CODES-1:0] RSVD_MAP =
        {16'h8920, 16'h8120, 16'h8020, 16'h8020}
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         sel_we,
    input  logic [CODE_W-1:0]         sel_wdata,
    input  logic [NUM_CH-1:0]         ch_en,
    input  logic [NUM_CH-1:0]         sw_trig,
    input  logic [NUM_CH-1:0]         ext_req,
    input  logic [NUM_CH*NUM_PER-1:0] per_src,
    input  logic                      conv_done,
    output logic [NUM_CH-1:0]         dma_req,
    output logic [NUM_CH-1:0]         cpu_irq
);
    logic                     conv_last;
    logic                     conv_pulse;
    logic [NUM_CH-1:0]        ext_rise;
    logic [NUM_CH-1:0]        ext_fall;
    logic [NUM_CH-1:0]        hw_cause;
    logic [NUM_CH*CODE_W-1:0] sel_q;

    // Edge the shared conversion-complete level once for all channels.
    always_ff @(posedge clk) begin
        if (!rst_n) conv_last <= 1'b0;
        else conv_last <= conv_done;
    end

    assign conv_pulse = conv_done & ~conv_last;

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            trig_ext_edge #(.STAGES(SYNC_STAGES)) i_edge (
                .clk  (clk),
                .rst_n(rst_n),
                .pin  (ext_req[c]),
                .rise (ext_rise[c]),
                .fall (ext_fall[c])
            );

            trig_chan #(.RSVD(RSVD_MAP[c*NUM_CODES +: NUM_CODES])) i_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .sel_we    (sel_we[c]),
                .sel_wdata (sel_wdata),
                .en        (ch_en[c]),
                .sw        (sw_trig[c]),
                .ext_rise  (ext_rise[c]),
                .ext_fall  (ext_fall[c]),
                .per_lvl   (per_src[c*NUM_PER +: NUM_PER]),
                .conv_pulse(conv_pulse),
                .sel_q     (sel_q[c*CODE_W +: CODE_W]),
                .req       (dma_req[c]),
                .hw        (hw_cause[c])
            );

            trig_irq_delay #(.DEPTH(IRQ_LAG)) i_irq (
                .clk  (clk),
                .rst_n(rst_n),
                .d    (hw_cause[c]),
                .q    (cpu_irq[c])
            );
        end
    endgenerate
endmodule

// File: rtl/dma_trig_router_chk.sv
// Property checker for dma_trig_router, attached by bind below.
// Assumes the default interrupt lag of two clocks.
module dma_trig_router_chk
    import dma_trig_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter logic [NUM_CH*NUM_CODES-1:0] RSVD_MAP = '0
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_CH-1:0]        ch_en,
    input logic [NUM_CH-1:0]        sw_trig,
    input logic [NUM_CH*CODE_W-1:0] sel_q,
    input logic [NUM_CH-1:0]        dma_req,
    input logic [NUM_CH-1:0]        cpu_irq
);
    logic [NUM_CH-1:0] rsvd_sel;
    logic [NUM_CH-1:0] sw_sel;

    // Decode per channel whether the held code is reserved or software.
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            rsvd_sel[c] = RSVD_MAP[c*NUM_CODES + int'(sel_q[c*CODE_W +: CODE_W])];
            sw_sel[c]   = (sel_q[c*CODE_W +: CODE_W] == CODE_SW);
        end
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_p
            p_sw_request_r1: assert property (@(posedge clk) disable iff (!rst_n)
                $past(sw_trig[c] && ch_en[c] && sw_sel[c]) |-> dma_req[c]);
            p_reserved_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rsvd_sel[c]) |-> !dma_req[c]);
            p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
                !$past(ch_en[c]) |-> !dma_req[c]);
            p_irq_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
                cpu_irq[c] |-> $past(dma_req[c], 2));
        end
    endgenerate
endmodule

bind dma_trig_router dma_trig_router_chk #(
    .NUM_CH  (NUM_CH),
    .RSVD_MAP(RSVD_MAP)
) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ch_en  (ch_en),
    .sw_trig(sw_trig),
    .sel_q  (sel_q),
    .dma_req(dma_req),
    .cpu_irq(cpu_irq)
);

// File: tb/test_dma_trig_router.sv
module test_dma_trig_router;
    localparam int NCH = 4;
    localparam int NPER = 10;
    localparam logic [1:0] K_SW = 2'd0, K_FALL = 2'd1, K_RISE = 2'd2, K_PER = 2'd3;
    // fields: tag, ch, code, kind, idx, en, exp_req, lag, exp_irq
    localparam int NV = 18;
    localparam logic [22:0] VEC [NV] = '{
        {4'd1, 2'd0, 4'd0,  K_SW,   4'd0, 1'b1, 1'b1, 4'd1, 1'b0}, // R1 software
        {4'd2, 2'd1, 4'd1,  K_FALL, 4'd0, 1'b1, 1'b1, 4'd3, 1'b1}, // R2 falling
        {4'd3, 2'd2, 4'd2,  K_RISE, 4'd0, 1'b1, 1'b1, 4'd3, 1'b1}, // R3 rising
        {4'd2, 2'd3, 4'd1,  K_RISE, 4'd0, 1'b1, 1'b0, 4'd0, 1'b0}, // R2 rise ignored
        {4'd3, 2'd2, 4'd2,  K_FALL, 4'd0, 1'b1, 1'b0, 4'd0, 1'b0}, // R3 fall ignored
        {4'd6, 2'd0, 4'd3,  K_PER,  4'd0, 1'b1, 1'b1, 4'd1, 1'b1}, // R6 idx0
        {4'd6, 2'd1, 4'd14, K_PER,  4'd9, 1'b1, 1'b1, 4'd1, 1'b1}, // R6 idx9
        {4'd6, 2'd2, 4'd9,  K_PER,  4'd5, 1'b1, 1'b1, 4'd1, 1'b1}, // R6 idx5
        {4'd6, 2'd1, 4'd13, K_PER,  4'd8, 1'b1, 1'b1, 4'd1, 1'b1}, // R6 idx8
        {4'd6, 2'd0, 4'd8,  K_PER,  4'd4, 1'b1, 1'b1, 4'd1, 1'b1}, // R6 idx4 ch0
        {4'd4, 2'd3, 4'd5,  K_SW,   4'd0, 1'b1, 1'b0, 4'd0, 1'b0}, // R4 code 0101
        {4'd4, 2'd0, 4'd15, K_SW,   4'd0, 1'b1, 1'b0, 4'd0, 1'b0}, // R4 code 1111
        {4'd4, 2'd3, 4'd8,  K_PER,  4'd4, 1'b1, 1'b0, 4'd0, 1'b0}, // R4 ch3 1000
        {4'd4, 2'd3, 4'd11, K_PER,  4'd7, 1'b1, 1'b0, 4'd0, 1'b0}, // R4 ch3 1011
        {4'd4, 2'd2, 4'd8,  K_PER,  4'd4, 1'b1, 1'b0, 4'd0, 1'b0}, // R4 ch2 1000
        {4'd5, 2'd1, 4'd7,  K_PER,  4'd3, 1'b0, 1'b0, 4'd0, 1'b0}, // R5 disabled
        {4'd5, 2'd2, 4'd0,  K_SW,   4'd0, 1'b0, 1'b0, 4'd0, 1'b0}, // R5 disabled sw
        {4'd9, 2'd0, 4'd1,  K_SW,   4'd0, 1'b1, 1'b0, 4'd0, 1'b0}  // R9 strobe ignored
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] sel_we = '0;
    logic [3:0] sel_wdata = '0;
    logic [NCH-1:0] ch_en = '0;
    logic [NCH-1:0] sw_trig = '0;
    logic [NCH-1:0] ext_req = '1;
    logic [NCH*NPER-1:0] per_src = '0;
    logic conv_done = 1'b0;
    logic [NCH-1:0] dma_req;
    logic [NCH-1:0] cpu_irq;
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    dma_trig_router i_dma_trig_router (
        .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
        .ch_en(ch_en), .sw_trig(sw_trig), .ext_req(ext_req), .per_src(per_src),
        .conv_done(conv_done), .dma_req(dma_req), .cpu_irq(cpu_irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_sel(input int ch, input logic [3:0] code);
        sel_we[ch] = 1'b1;
        sel_wdata = code;
        tick(1);
        sel_we = '0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        tick(4);
        chk(dma_req == 0 && cpu_irq == 0, "R1 reset outputs", int'({dma_req, cpu_irq}), 0);
        rst_n = 1'b1;
        ch_en = '1;
        tick(1);
        // R1: default code is software on every channel; R8: no irq for it
        sw_trig = '1;
        tick(1);
        sw_trig = '0;
        chk(dma_req == 4'hF, "R1 default software", int'(dma_req), 15);
        tick(1);
        chk(dma_req == 4'h0, "R1 single pulse", int'(dma_req), 0);
        tick(1);
        chk(cpu_irq == 4'h0, "R8 no irq for software", int'(cpu_irq), 0);
        tick(3);

        for (int v = 0; v < NV; v++) begin
            logic [3:0] tag, code, idx, lag;
            logic [1:0] ch, kind;
            logic en, ereq, eirq;
            int rc, rfirst, ic, ifirst;
            {tag, ch, code, kind, idx, en, ereq, lag, eirq} = VEC[v];
            ch_en = '1;
            ch_en[ch] = en;
            set_sel(int'(ch), code);
            if (kind == K_RISE) begin
                ext_req[ch] = 1'b0;
                tick(7);
            end
            case (kind)
                K_SW:   sw_trig[ch] = 1'b1;
                K_FALL: ext_req[ch] = 1'b0;
                K_RISE: ext_req[ch] = 1'b1;
                default: per_src[int'(ch)*NPER + int'(idx)] = 1'b1;
            endcase
            rc = 0; rfirst = 0; ic = 0; ifirst = 0;
            for (int s = 1; s <= 8; s++) begin
                tick(1);
                if (dma_req[ch]) begin rc++; if (rfirst == 0) rfirst = s; end
                if (cpu_irq[ch]) begin ic++; if (ifirst == 0) ifirst = s; end
                sw_trig = '0;
            end
            chk(rc == int'(ereq), $sformatf("R%0d vec %0d request count", tag, v), rc, int'(ereq));
            if (ereq)
                chk(rfirst == int'(lag), $sformatf("R%0d vec %0d request lag", tag, v), rfirst, int'(lag));
            chk(ic == int'(eirq), $sformatf("R8 vec %0d irq count", v), ic, int'(eirq));
            if (eirq)
                chk(ifirst == int'(lag) + 2, $sformatf("R8 vec %0d irq lag", v), ifirst, int'(lag) + 2);
            ext_req = '1;
            per_src = '0;
            tick(7);
        end

        // R7: shared conversion event fires all channels together
        ch_en = '1;
        for (int c = 0; c < NCH; c++) set_sel(c, 4'd12);
        conv_done = 1'b1;
        tick(1);
        chk(dma_req == 4'hF, "R7 all channels same cycle", int'(dma_req), 15);
        tick(1);
        chk(dma_req == 4'h0, "R7 held level no repeat", int'(dma_req), 0);
        tick(1);
        chk(cpu_irq == 4'hF, "R8 irq two clocks later", int'(cpu_irq), 15);
        tick(1);
        chk(cpu_irq == 4'h0, "R8 irq one cycle", int'(cpu_irq), 0);
        conv_done = 1'b0;
        tick(3);

        // R5: disabling one channel leaves the others firing
        ch_en = 4'b1011;
        conv_done = 1'b1;
        tick(1);
        chk(dma_req == 4'b1011, "R5 disabled channel quiet", int'(dma_req), 11);
        conv_done = 1'b0;
        tick(4);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule